// File: doc/BRIEF.md
# Scanline Interrupt Register Interface

This block is the processor-side register file of a tile video controller. The processor reaches its registers through four byte ports. One port picks which internal register is addressed, and another reads that selection back. A pair of byte ports holds the low and high halves of a 16-bit value. The register file holds a horizontal scroll value and a line-compare value. An internal line counter steps on each line strobe. When the counter enters the compare line, the block raises a line interrupt. When it enters the first blanking line, it raises a blanking interrupt. Both interrupts drive one active-high interrupt output.

An interrupt handler reads the status port to learn which source fired, and that read also clears both flags. The handler can read back the current register selection, change it for its own writes, and then restore the selection the interrupted code was using. The compare can match any of the 262 lines of the frame, including lines inside vertical blanking. This allows one line event per line across the whole frame. The scroll value is presented on an output and is refreshed only at each line start.

Top module: `vid_reg_if`

## Requirements
- R1: A write to port 0 loads the register select index from the low 5 data bits, and a read of port 1 returns that index.
- R2: A write to port 2 only stages a low byte. A write to port 3 commits {port 3 data, staged byte} as one 16-bit value into the selected register. Reads of ports 2 and 3 return the selected register's low and high bytes.
- R3: Register index 7 is the horizontal scroll. It is copied to `scroll_o` on each line strobe, so a scroll write reaches the output only at the next line start.
- R4: Register index 6 is the line compare. When a strobe moves the counter onto the compare line, status bit 2 sets.
- R5: When a strobe moves the counter onto line 224 (the first blanking line), status bit 5 sets.
- R6: The line counter resets to 0, steps by one per strobe, wraps from 261 to 0, and the compare matches on blanking lines and on line 0.
- R7: A read of port 0 returns the status byte, clears both flags, and `irq_o` is low in the next cycle when no strobe arrives.
- R8: Register indices other than 6 and 7 read back as zero, and writes to them alter neither register 6 nor register 7.
- R9: After reset, the select index, both registers, `scroll_o`, `line_o`, the status byte and `irq_o` are all zero.
- R10: `irq_o` is high while either status flag is set, and it rises only in the cycle after a line strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Processor write strobe |
| rd_i | input | 1 | Processor read strobe |
| addr_i | input | 2 | Byte port: 0 status/select, 1 select readback, 2 data low, 3 data high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when rd_i is low |
| hsync_i | input | 1 | One-cycle line-start strobe |
| line_o | output | 9 | Current line number |
| scroll_o | output | 16 | Horizontal scroll latched at line start |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The checker assumes that `hsync_i` is a one-cycle pulse and is never asserted on back-to-back cycles. It also assumes that a status read and a line strobe can fall in the same cycle, and in that case a new event wins over the acknowledge. For this reason the acknowledge property applies only to reads made without a strobe. The stimulus always separates strobes by at least one idle cycle, and it makes every processor access between strobes. This keeps all register writes and status reads clear of line starts.

// File: rtl/vid_reg_pkg.sv
package vid_reg_pkg;
  localparam int REG_CMP     = 6;
  localparam int REG_SCR     = 7;
  localparam int ST_LINE_BIT = 2;
  localparam int ST_VBL_BIT  = 5;

  typedef enum logic [1:0] {
    P_STAT = 2'd0,
    P_SEL  = 2'd1,
    P_DLO  = 2'd2,
    P_DHI  = 2'd3
  } port_e;
endpackage

// File: rtl/vid_line_ctr.sv
module vid_line_ctr #(
  parameter int LINES  = 262,
  parameter int VIS    = 224,
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic [15:0]       cmp_i,
  output logic [LINE_W-1:0] line_o,
  output logic              line_hit_o,
  output logic              vbl_hit_o
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] VBL  = LINE_W'(VIS);

  logic [LINE_W-1:0] nxt;

  assign nxt        = (line_o == LAST) ? '0 : line_o + LINE_W'(1);
  assign line_hit_o = hsync_i && (16'(nxt) == cmp_i);
  assign vbl_hit_o  = hsync_i && (nxt == VBL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      line_o <= '0;
    else if (hsync_i) line_o <= nxt;
  end
endmodule

// File: rtl/vid_reg_bank.sv
module vid_reg_bank
  import vid_reg_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [IDX_W-1:0] sel_o,
  output logic [15:0]      scr_o,
  output logic [15:0]      cmp_o,
  output logic [15:0]      sel_val_o
);
  localparam logic [IDX_W-1:0] I_CMP = IDX_W'(REG_CMP);
  localparam logic [IDX_W-1:0] I_SCR = IDX_W'(REG_SCR);

  logic [7:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= '0;
      stage_q <= '0;
      scr_o   <= '0;
      cmp_o   <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        P_STAT:  sel_o   <= wdata_i[IDX_W-1:0];
        P_DLO:   stage_q <= wdata_i;
        P_DHI: begin
          // commit on high byte only
          if (sel_o == I_CMP)      cmp_o <= {wdata_i, stage_q};
          else if (sel_o == I_SCR) scr_o <= {wdata_i, stage_q};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (sel_o == I_CMP)      sel_val_o = cmp_o;
    else if (sel_o == I_SCR) sel_val_o = scr_o;
    else                     sel_val_o = '0;
  end
endmodule

// File: rtl/vid_irq_ctl.sv
module vid_irq_ctl
  import vid_reg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_hit_i,
  input  logic       vbl_hit_i,
  input  logic       ack_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic line_q, vbl_q;

  // a new event in the acknowledge cycle is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      vbl_q  <= 1'b0;
    end else begin
      line_q <= line_hit_i | (line_q & ~ack_i);
      vbl_q  <= vbl_hit_i  | (vbl_q  & ~ack_i);
    end
  end

  always_comb begin
    status_o              = '0;
    status_o[ST_LINE_BIT] = line_q;
    status_o[ST_VBL_BIT]  = vbl_q;
  end

  assign irq_o = line_q | vbl_q;
endmodule

// File: rtl/vid_reg_if.sv
module vid_reg_if
  import vid_reg_pkg::*;
#(
  parameter int LINES  = 262,
  parameter int VIS    = 224,
  parameter int IDX_W  = 5,
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              hsync_i,
  output logic [LINE_W-1:0] line_o,
  output logic [15:0]       scroll_o,
  output logic              irq_o
);
  logic [IDX_W-1:0] sel;
  logic [15:0]      scr, cmp, sel_val;
  logic [7:0]       status;
  logic             line_hit, vbl_hit, ack;

  assign ack = rd_i && (addr_i == P_STAT);

  vid_reg_bank #(.IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .sel_o(sel), .scr_o(scr), .cmp_o(cmp), .sel_val_o(sel_val)
  );

  vid_line_ctr #(.LINES(LINES), .VIS(VIS), .LINE_W(LINE_W)) u_ctr (
    .clk_i, .rst_ni, .hsync_i, .cmp_i(cmp),
    .line_o, .line_hit_o(line_hit), .vbl_hit_o(vbl_hit)
  );

  vid_irq_ctl u_irq (
    .clk_i, .rst_ni, .line_hit_i(line_hit), .vbl_hit_i(vbl_hit),
    .ack_i(ack), .status_o(status), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      scroll_o <= '0;
    else if (hsync_i) scroll_o <= scr;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        P_STAT: rdata_o = status;
        P_SEL:  rdata_o = 8'(sel);
        P_DLO:  rdata_o = sel_val[7:0];
        P_DHI:  rdata_o = sel_val[15:8];
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vid_reg_if_chk.sv
module vid_reg_if_chk #(
  parameter int LINES  = 262,
  parameter int LINE_W = $clog2(LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hsync_i,
  input logic              rd_i,
  input logic [1:0]        addr_i,
  input logic [LINE_W-1:0] line_o,
  input logic [15:0]       scroll_o,
  input logic              irq_o
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LINES - 1);

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i && line_o == LAST |=> line_o == '0);

  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i && line_o != LAST |=> line_o == $past(line_o) + LINE_W'(1));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_i |=> $stable(line_o));

  a_r6_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o <= LAST);

  a_r3_scroll_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_i |=> $stable(scroll_o));

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 2'd0 && !hsync_i |=> !irq_o);

  a_r10_rise_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(hsync_i));
endmodule

bind vid_reg_if vid_reg_if_chk #(.LINES(LINES), .LINE_W(LINE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .rd_i(rd_i),
  .addr_i(addr_i), .line_o(line_o), .scroll_o(scroll_o), .irq_o(irq_o)
);

// File: tb/vid_reg_if_bench.sv
module vid_reg_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, hs = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [8:0]  line;
  logic [15:0] scroll;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  int          exp_line = 0;

  always #4 clk = ~clk;

  vid_reg_if u_vid_reg_if (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .hsync_i(hs), .line_o(line),
    .scroll_o(scroll), .irq_o(irq)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_reg(logic [7:0] idx, logic [15:0] v);
    cpu_wr(2'd0, idx);
    cpu_wr(2'd2, v[7:0]);
    cpu_wr(2'd3, v[15:8]);
  endtask

  task automatic strobe();
    @(negedge clk); hs = 1'b1;
    @(negedge clk); hs = 1'b0;
    exp_line = (exp_line == 261) ? 0 : exp_line + 1;
  endtask

  task automatic run_to(int target);
    while (exp_line != target) strobe();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R9 line", line, 0);
    check("R9 scroll", scroll, 0);
    check("R9 irq", irq, 0);
    cpu_rd(2'd0, d); check("R9 status", d, 0);
    cpu_rd(2'd1, d); check("R9 select", d, 0);
  endtask

  task automatic t_select();
    logic [7:0] d;
    cpu_wr(2'd0, 8'd7);
    cpu_rd(2'd1, d); check("R1 sel 7", d, 7);
    cpu_wr(2'd0, 8'd19);
    cpu_rd(2'd1, d); check("R1 sel 19", d, 19);
  endtask

  task automatic t_stage();
    logic [7:0] d;
    cpu_wr(2'd0, 8'd7);
    cpu_wr(2'd2, 8'h34);
    cpu_rd(2'd2, d); check("R2 low staged only", d, 0);
    cpu_wr(2'd3, 8'h12);
    cpu_rd(2'd2, d); check("R2 low committed", d, 8'h34);
    cpu_rd(2'd3, d); check("R2 high committed", d, 8'h12);
  endtask

  task automatic t_scroll();
    check("R3 scroll before strobe", scroll, 0);
    strobe();
    check("R3 scroll after strobe", scroll, 16'h1234);
    check("R6 line step", line, exp_line);
    wr_reg(8'd7, 16'hBEEF);
    check("R3 mid-line write held", scroll, 16'h1234);
    strobe();
    check("R3 next line", scroll, 16'hBEEF);
  endtask

  task automatic t_other();
    logic [7:0] d;
    wr_reg(8'd3, 16'hA5A5);
    cpu_rd(2'd2, d); check("R8 idx3 low", d, 0);
    cpu_rd(2'd3, d); check("R8 idx3 high", d, 0);
    cpu_wr(2'd0, 8'd7);
    cpu_rd(2'd3, d); check("R8 scroll untouched", d, 8'hBE);
    cpu_wr(2'd0, 8'd6);
    cpu_rd(2'd2, d); check("R8 cmp untouched", d, 0);
  endtask

  task automatic t_cmp();
    logic [7:0] d;
    wr_reg(8'd6, 16'd5);
    run_to(4);
    check("R4 no hit before", irq, 0);
    strobe();
    check("R10 irq on hit", irq, 1);
    cpu_rd(2'd0, d); check("R4 status line bit", d, 8'h04);
    check("R7 irq cleared", irq, 0);
    cpu_rd(2'd0, d); check("R7 status cleared", d, 0);
  endtask

  task automatic t_vblank();
    logic [7:0] d;
    run_to(223);
    check("R5 no vblank at 223", irq, 0);
    strobe();
    check("R5 line 224", line, 224);
    cpu_rd(2'd0, d); check("R5 status vblank bit", d, 8'h20);
    check("R7 irq low", irq, 0);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    wr_reg(8'd6, 16'd250);
    run_to(250);
    cpu_rd(2'd0, d); check("R6 hit in blanking", d, 8'h04);
    wr_reg(8'd6, 16'd0);
    run_to(261);
    check("R6 line 261", line, 261);
    check("R6 no irq before wrap", irq, 0);
    strobe();
    check("R6 wrapped", line, 0);
    cpu_rd(2'd0, d); check("R6 hit on line 0", d, 8'h04);
  endtask

  task automatic t_both();
    logic [7:0] d;
    wr_reg(8'd6, 16'd224);
    run_to(224);
    check("R10 irq both", irq, 1);
    cpu_rd(2'd0, d); check("R4 R5 both bits", d, 8'h24);
    check("R7 irq low after both", irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_stage();
        t_scroll();
        t_other();
        t_cmp();
        t_vblank();
        t_wrap();
        t_both();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule